// File: doc/BRIEF.md
# ECG Fiducial Point Extractor

This block locates the Q, S, P and T wave peaks of one heartbeat. The caller supplies the sample index of the R wave and the QRS onset and offset positions, both counted in level-3 wavelet coefficient units. The raw ECG sample store and the level-5 detail coefficient store stay outside the block. Each is reached through a synchronous single-port read interface: an address is presented in one cycle and the data returns in the next.

One start pulse processes one beat. The block first reads the sample at the R index, and its sign sets how the Q and S searches run. It then scans the Q window and the S window. Next it takes the level-5 extremes before the QRS onset and after the QRS offset. These extremes are widened into raw-sample windows, and the largest-magnitude sample in each window becomes the P peak or the T peak. A single scanning datapath per store does all the searches one after another. Every scaling step is a bit append or a bit drop, so the block has no multiplier and no shifter. When all four indices are ready they are presented together with a one-cycle completion pulse.

Top module: `ecg_fiducial_extractor`

## Requirements
- R1: After a synchronous active-low reset, `beat_done` is 0 and all four peak outputs are 0.
- R2: The sample read at `r_idx` sets the search sense. Bit DW-1 clear (a non-negative value) makes Q and S minimum searches. Bit DW-1 set makes them maximum searches.
- R3: Q is the index of the extreme raw sample over the inclusive range between `qrs_begin` with three zero bits appended and `r_idx`. Either endpoint order is accepted.
- R4: S is the index of the extreme raw sample over the inclusive range between `r_idx` and `qrs_end` with three zero bits appended. Either endpoint order is accepted.
- R5: For P, the block finds the maximum and the minimum coefficient over coefficient addresses 0 to `qrs_begin` with its two low bits dropped. Each of the two addresses gets five zero bits appended. P is the index of the largest-magnitude raw sample between the two results, and the result does not depend on which endpoint is the larger.
- R6: T uses the method of R5 over coefficient addresses from `qrs_end` with its two low bits dropped up to the last coefficient address, 2^(SAMP_AW-5)-1.
- R7: In every minimum, maximum or magnitude search, a tie keeps the lowest index, because each window is scanned in ascending order.
- R8: `beat_done` is high for exactly one cycle per beat. In that cycle the four outputs carry the new indices, and they then hold until the next completion.
- R9: A `start` pulse that arrives while a beat is in progress is ignored, and the running beat finishes with the inputs it captured.
- R10: Magnitude comparison covers the most negative sample value, so -2^(DW-1) outranks +2^(DW-1)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one beat; inputs are captured in the same cycle |
| r_idx | input | SAMP_AW | R-peak raw sample index |
| qrs_begin | input | SAMP_AW-3 | QRS onset in level-3 coefficient units |
| qrs_end | input | SAMP_AW-3 | QRS offset in level-3 coefficient units |
| raw_addr | output | SAMP_AW | Raw sample store read address |
| raw_data | input | DW | Raw sample, signed, one cycle after its address |
| coef_addr | output | SAMP_AW-5 | Level-5 coefficient store read address |
| coef_data | input | CW | Coefficient, signed, one cycle after its address |
| beat_done | output | 1 | One-cycle completion pulse |
| q_pos | output | SAMP_AW | Q peak index |
| s_pos | output | SAMP_AW | S peak index |
| p_pos | output | SAMP_AW | P peak index |
| t_pos | output | SAMP_AW | T peak index |

## Verification
The assertions assume that both stores answer every address with exactly one cycle of read latency. They also assume that the Q and S windows captured at an accepted start are the ones the result refers to. The bench meets the first assumption with memory models that register the read on the clock edge. It meets the second by changing `r_idx` and the QRS inputs only in the cycle where `start` is driven. The bench rewrites the stores only between beats, so each search sees stable contents for the whole beat.

// File: rtl/fid_pkg.sv
// Shared types for the fiducial extractor: the scan kinds and the beat sequencer states.
package fid_pkg;
    // Scaling of level-3 and level-5 coefficient positions into raw sample positions.
    localparam int SH_L3 = 3;
    localparam int SH_L5 = 5;

    typedef enum logic [1:0] {
        SCAN_MIN,
        SCAN_MAX,
        SCAN_ABS,
        SCAN_MINMAX
    } scan_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RREAD,
        ST_RSIGN,
        ST_QWAIT,
        ST_SWAIT,
        ST_PCWAIT,
        ST_PRWAIT,
        ST_TCWAIT,
        ST_TRWAIT
    } fid_state_e;
endpackage

// File: rtl/fid_scan.sv
// Sequential extreme search over an inclusive address window of a synchronous-read store.
// Assumes: read data arrives one cycle after the address; go is pulsed only when idle.
// The window is taken in either endpoint order. Ties keep the lowest (first) address.
// DUAL=1 also tracks the minimum next to the primary result (primary is then the maximum).
module fid_scan
    import fid_pkg::*;
#(
    parameter int AW   = 6,
    parameter int DW   = 14,
    parameter bit DUAL = 1'b0,
    localparam int NRES = DUAL ? 2 : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  scan_mode_e           mode,
    input  logic [AW-1:0]        lo,
    input  logic [AW-1:0]        hi,
    output logic [AW-1:0]        rd_addr,
    input  logic signed [DW-1:0] rd_data,
    output logic                 done,
    output logic [NRES*AW-1:0]   idx
);
    localparam int KW = DW + 1;

    logic                 issuing;
    logic [AW-1:0]        cur;
    logic [AW-1:0]        stop;
    logic                 pend;
    logic [AW-1:0]        pend_idx;
    logic                 pend_last;
    logic                 first;
    scan_mode_e           mode_q;
    logic signed [KW-1:0] key;
    logic signed [KW-1:0] key_a;
    logic [AW-1:0]        idx_a;
    logic signed [KW-1:0] ext;
    logic                 better_a;

    assign rd_addr = cur;

    // Form the comparison key: signed value, or its magnitude in one extra bit.
    always_comb begin
        ext = {rd_data[DW-1], rd_data};
        if (mode_q == SCAN_ABS && rd_data[DW-1]) key = -ext;
        else                                      key = ext;
        better_a = (mode_q == SCAN_MIN) ? (key < key_a) : (key > key_a);
    end

    // Issue addresses across the window and fold returning data into the primary result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issuing   <= 1'b0;
            cur       <= '0;
            stop      <= '0;
            pend      <= 1'b0;
            pend_idx  <= '0;
            pend_last <= 1'b0;
            first     <= 1'b0;
            mode_q    <= SCAN_MIN;
            key_a     <= '0;
            idx_a     <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                cur     <= (lo <= hi) ? lo : hi;
                stop    <= (lo <= hi) ? hi : lo;
                issuing <= 1'b1;
                pend    <= 1'b0;
                first   <= 1'b1;
                mode_q  <= mode;
            end else begin
                pend <= issuing;
                if (issuing) begin
                    pend_idx  <= cur;
                    pend_last <= (cur == stop);
                    if (cur == stop) issuing <= 1'b0;
                    else             cur     <= cur + 1'b1;
                end
                if (pend) begin
                    first <= 1'b0;
                    if (first || better_a) begin
                        key_a <= key;
                        idx_a <= pend_idx;
                    end
                    if (pend_last) done <= 1'b1;
                end
            end
        end
    end

    generate
        if (DUAL) begin : g_dual
            logic signed [DW-1:0] val_b;
            logic [AW-1:0]        idx_b;
            // Track the minimum alongside the maximum during the same pass.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_b <= '0;
                    idx_b <= '0;
                end else if (!go && pend && (first || rd_data < val_b)) begin
                    val_b <= rd_data;
                    idx_b <= pend_idx;
                end
            end
            assign idx = {idx_b, idx_a};
        end else begin : g_single
            assign idx = idx_a;
        end
    endgenerate
endmodule

// File: rtl/fid_window.sv
// Forms each search window and scan kind from the sequencer state.
// All scaling is done by appending or dropping low zero bits. Assumes SAMP_AW > SH_L5.
module fid_window
    import fid_pkg::*;
#(
    parameter int SAMP_AW = 11,
    localparam int L3_AW = SAMP_AW - SH_L3,
    localparam int C5_AW = SAMP_AW - SH_L5
) (
    input  fid_state_e         state,
    input  logic [SAMP_AW-1:0] r_l,
    input  logic [L3_AW-1:0]   beg_l,
    input  logic [L3_AW-1:0]   end_l,
    input  logic               sign_now,
    input  logic               sign_q,
    input  logic [C5_AW-1:0]   c_max,
    input  logic [C5_AW-1:0]   c_min,
    output scan_mode_e         raw_mode,
    output logic [SAMP_AW-1:0] raw_lo,
    output logic [SAMP_AW-1:0] raw_hi,
    output logic [C5_AW-1:0]   c_lo,
    output logic [C5_AW-1:0]   c_hi
);
    // Select the raw sample window that the state is about to launch.
    always_comb begin
        raw_mode = SCAN_MIN;
        raw_lo   = '0;
        raw_hi   = '0;
        case (state)
            ST_RSIGN: begin
                raw_mode = sign_now ? SCAN_MAX : SCAN_MIN;
                raw_lo   = {beg_l, {SH_L3{1'b0}}};
                raw_hi   = r_l;
            end
            ST_QWAIT: begin
                raw_mode = sign_q ? SCAN_MAX : SCAN_MIN;
                raw_lo   = r_l;
                raw_hi   = {end_l, {SH_L3{1'b0}}};
            end
            ST_PCWAIT, ST_TCWAIT: begin
                raw_mode = SCAN_ABS;
                raw_lo   = {c_max, {SH_L5{1'b0}}};
                raw_hi   = {c_min, {SH_L5{1'b0}}};
            end
            default: ;
        endcase
    end

    // Select the level-5 coefficient window for the P or T pass.
    always_comb begin
        c_lo = '0;
        c_hi = '0;
        case (state)
            ST_SWAIT: begin
                c_lo = '0;
                c_hi = beg_l[L3_AW-1:L3_AW-C5_AW];
            end
            ST_PRWAIT: begin
                c_lo = end_l[L3_AW-1:L3_AW-C5_AW];
                c_hi = '1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ecg_fiducial_extractor.sv
// Top of the fiducial extractor. Runs one beat per accepted start: R sign read, Q scan,
// S scan, P coefficient pass, P magnitude scan, T coefficient pass, T magnitude scan.
// Assumes both stores have one cycle of read latency. A start while busy is ignored.
module ecg_fiducial_extractor
    import fid_pkg::*;
#(
    parameter int SAMP_AW = 11,
    parameter int DW      = 12,
    parameter int CW      = 14,
    localparam int L3_AW  = SAMP_AW - SH_L3,
    localparam int C5_AW  = SAMP_AW - SH_L5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [SAMP_AW-1:0]   r_idx,
    input  logic [L3_AW-1:0]     qrs_begin,
    input  logic [L3_AW-1:0]     qrs_end,
    output logic [SAMP_AW-1:0]   raw_addr,
    input  logic signed [DW-1:0] raw_data,
    output logic [C5_AW-1:0]     coef_addr,
    input  logic signed [CW-1:0] coef_data,
    output logic                 beat_done,
    output logic [SAMP_AW-1:0]   q_pos,
    output logic [SAMP_AW-1:0]   s_pos,
    output logic [SAMP_AW-1:0]   p_pos,
    output logic [SAMP_AW-1:0]   t_pos
);
    fid_state_e         state;
    logic               busy;
    logic [SAMP_AW-1:0] r_l;
    logic [L3_AW-1:0]   beg_l, end_l;
    logic               sign_q;
    logic [SAMP_AW-1:0] q_l, s_l, p_l;

    logic                 raw_go, raw_done;
    scan_mode_e           raw_mode;
    logic [SAMP_AW-1:0]   raw_lo, raw_hi, raw_scan_addr, raw_idx;
    logic                 c_go, c_done;
    logic [C5_AW-1:0]     c_lo, c_hi;
    logic [2*C5_AW-1:0]   c_idx;

    assign busy = (state != ST_IDLE);

    // Launch the raw scanner when the previous step completes.
    assign raw_go = (state == ST_RSIGN)
                  || (raw_done && state == ST_QWAIT)
                  || (c_done && (state == ST_PCWAIT || state == ST_TCWAIT));
    // Launch the coefficient scanner after the S and P raw scans.
    assign c_go   = raw_done && (state == ST_SWAIT || state == ST_PRWAIT);
    // The R sign read borrows the raw port for one cycle.
    assign raw_addr = (state == ST_RREAD) ? r_l : raw_scan_addr;

    fid_window #(.SAMP_AW(SAMP_AW)) u_window (
        .state    (state),
        .r_l      (r_l),
        .beg_l    (beg_l),
        .end_l    (end_l),
        .sign_now (raw_data[DW-1]),
        .sign_q   (sign_q),
        .c_max    (c_idx[C5_AW-1:0]),
        .c_min    (c_idx[2*C5_AW-1:C5_AW]),
        .raw_mode (raw_mode),
        .raw_lo   (raw_lo),
        .raw_hi   (raw_hi),
        .c_lo     (c_lo),
        .c_hi     (c_hi)
    );

    fid_scan #(.AW(SAMP_AW), .DW(DW), .DUAL(1'b0)) u_raw_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (raw_go),
        .mode    (raw_mode),
        .lo      (raw_lo),
        .hi      (raw_hi),
        .rd_addr (raw_scan_addr),
        .rd_data (raw_data),
        .done    (raw_done),
        .idx     (raw_idx)
    );

    fid_scan #(.AW(C5_AW), .DW(CW), .DUAL(1'b1)) u_coef_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (c_go),
        .mode    (SCAN_MINMAX),
        .lo      (c_lo),
        .hi      (c_hi),
        .rd_addr (coef_addr),
        .rd_data (coef_data),
        .done    (c_done),
        .idx     (c_idx)
    );

    // Beat sequencer: captures inputs, steps through the scans, publishes results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            r_l       <= '0;
            beg_l     <= '0;
            end_l     <= '0;
            sign_q    <= 1'b0;
            q_l       <= '0;
            s_l       <= '0;
            p_l       <= '0;
            beat_done <= 1'b0;
            q_pos     <= '0;
            s_pos     <= '0;
            p_pos     <= '0;
            t_pos     <= '0;
        end else begin
            beat_done <= 1'b0;
            if (start && !busy) begin
                r_l   <= r_idx;
                beg_l <= qrs_begin;
                end_l <= qrs_end;
                state <= ST_RREAD;
            end else begin
                case (state)
                    ST_RREAD:  state <= ST_RSIGN;
                    ST_RSIGN: begin
                        sign_q <= raw_data[DW-1];
                        state  <= ST_QWAIT;
                    end
                    ST_QWAIT:  if (raw_done) begin q_l <= raw_idx; state <= ST_SWAIT; end
                    ST_SWAIT:  if (raw_done) begin s_l <= raw_idx; state <= ST_PCWAIT; end
                    ST_PCWAIT: if (c_done) state <= ST_PRWAIT;
                    ST_PRWAIT: if (raw_done) begin p_l <= raw_idx; state <= ST_TCWAIT; end
                    ST_TCWAIT: if (c_done) state <= ST_TRWAIT;
                    ST_TRWAIT: if (raw_done) begin
                        q_pos     <= q_l;
                        s_pos     <= s_l;
                        p_pos     <= p_l;
                        t_pos     <= raw_idx;
                        beat_done <= 1'b1;
                        state     <= ST_IDLE;
                    end
                    default:   state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/fid_checks.sv
// Property checker for the fiducial extractor, attached to the top by bind.
// Keeps its own copy of the window inputs captured at each accepted start.
module fid_checks #(
    parameter int SAMP_AW = 11,
    localparam int L3_AW  = SAMP_AW - 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               busy,
    input logic [SAMP_AW-1:0] r_idx,
    input logic [L3_AW-1:0]   qrs_begin,
    input logic [L3_AW-1:0]   qrs_end,
    input logic [SAMP_AW-1:0] raw_addr,
    input logic               beat_done,
    input logic [SAMP_AW-1:0] q_pos,
    input logic [SAMP_AW-1:0] s_pos
);
    logic [SAMP_AW-1:0] cap_r, beg_x, end_x;
    logic               seen;

    // Record the window inputs of the beat being processed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_r <= '0;
            beg_x <= '0;
            end_x <= '0;
            seen  <= 1'b0;
        end else if (start && !busy) begin
            cap_r <= r_idx;
            beg_x <= {qrs_begin, 3'b000};
            end_x <= {qrs_end, 3'b000};
            seen  <= 1'b1;
        end
    end

    a_r2_sign_read: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (raw_addr == $past(r_idx)));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done |=> !beat_done);

    a_r8_done_ends_beat: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done |-> (seen && !busy && $past(busy)));

    a_r3_q_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done |-> ((q_pos >= beg_x && q_pos <= cap_r) || (q_pos >= cap_r && q_pos <= beg_x)));

    a_r4_s_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        beat_done |-> ((s_pos >= cap_r && s_pos <= end_x) || (s_pos >= end_x && s_pos <= cap_r)));

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !beat_done) |=> (busy || beat_done));
endmodule

bind ecg_fiducial_extractor fid_checks #(.SAMP_AW(SAMP_AW)) u_fid_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .r_idx     (r_idx),
    .qrs_begin (qrs_begin),
    .qrs_end   (qrs_end),
    .raw_addr  (raw_addr),
    .beat_done (beat_done),
    .q_pos     (q_pos),
    .s_pos     (s_pos)
);

// File: tb/tb_ecg_fiducial_extractor.sv
`timescale 1ns/1ps
module tb_ecg_fiducial_extractor;
    localparam int SAMP_AW = 11;
    localparam int DW      = 12;
    localparam int CW      = 14;
    localparam int L3_AW   = SAMP_AW - 3;
    localparam int C5_AW   = SAMP_AW - 5;
    localparam int NS      = 1 << SAMP_AW;
    localparam int NC      = 1 << C5_AW;
    localparam int BEAT_LIMIT = 30000;
    localparam int WD_LIMIT   = 180000;

    typedef struct packed {
        logic [7:0]  seed;
        logic        neg;
        logic [10:0] r;
        logic [7:0]  qb;
        logic [7:0]  qe;
    } vec_t;

    // seed, R sign, R index, QRS begin, QRS end (level-3 units)
    localparam vec_t VECS [6] = '{
        '{8'd3,   1'b0, 11'd300,  8'd30,  8'd45},
        '{8'd17,  1'b1, 11'd800,  8'd95,  8'd110},
        '{8'd40,  1'b0, 11'd1500, 8'd180, 8'd195},
        '{8'd91,  1'b1, 11'd100,  8'd20,  8'd10},
        '{8'd5,   1'b0, 11'd2047, 8'd250, 8'd255},
        '{8'd200, 1'b1, 11'd0,    8'd0,   8'd0}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [SAMP_AW-1:0]   r_idx = '0;
    logic [L3_AW-1:0]     qrs_begin = '0;
    logic [L3_AW-1:0]     qrs_end = '0;
    logic [SAMP_AW-1:0]   raw_addr;
    logic signed [DW-1:0] raw_data;
    logic [C5_AW-1:0]     coef_addr;
    logic signed [CW-1:0] coef_data;
    logic                 beat_done;
    logic [SAMP_AW-1:0]   q_pos, s_pos, p_pos, t_pos;

    logic signed [DW-1:0] raw_mem [0:NS-1];
    logic signed [CW-1:0] coef_mem [0:NC-1];

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    ecg_fiducial_extractor dut (
        .clk(clk), .rst_n(rst_n), .start(start), .r_idx(r_idx),
        .qrs_begin(qrs_begin), .qrs_end(qrs_end),
        .raw_addr(raw_addr), .raw_data(raw_data),
        .coef_addr(coef_addr), .coef_data(coef_data),
        .beat_done(beat_done), .q_pos(q_pos), .s_pos(s_pos), .p_pos(p_pos), .t_pos(t_pos)
    );

    // Synchronous read stores with one cycle of latency.
    always @(posedge clk) begin
        raw_data  <= raw_mem[raw_addr];
        coef_data <= coef_mem[coef_addr];
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL R8 watchdog expired actual=%0d expected<=%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < NS; i++) begin
            logic [31:0] h;
            h = 32'(i) * 32'h9E3779B1 + 32'(seed) * 32'h85EBCA6B;
            h = h ^ (h >> 15);
            h = h * 32'h2C1B3C6D;
            h = h ^ (h >> 12);
            raw_mem[i] = h[DW-1:0];
        end
        for (int i = 0; i < NC; i++) begin
            logic [31:0] h;
            h = 32'(i) * 32'h7FEB352D + 32'(seed) * 32'h846CA68B;
            h = h ^ (h >> 13);
            h = h * 32'h165667B1;
            h = h ^ (h >> 16);
            coef_mem[i] = h[CW-1:0];
        end
    endtask

    // Reference raw search: kind 0 minimum, 1 maximum, 2 magnitude; ties keep the first.
    function automatic int ref_raw(input int a, input int b, input int kind);
        int lo = (a < b) ? a : b;
        int hi = (a < b) ? b : a;
        int bi = lo;
        int bk = int'(raw_mem[lo]);
        if (kind == 2 && bk < 0) bk = -bk;
        for (int i = lo + 1; i <= hi; i++) begin
            int k = int'(raw_mem[i]);
            if (kind == 2 && k < 0) k = -k;
            if ((kind == 0 && k < bk) || (kind != 0 && k > bk)) begin
                bk = k;
                bi = i;
            end
        end
        return bi;
    endfunction

    // Reference coefficient search: is_max selects maximum, else minimum; ties keep first.
    function automatic int ref_coef(input int lo, input int hi, input bit is_max);
        int bi = lo;
        int bv = int'(coef_mem[lo]);
        for (int i = lo + 1; i <= hi; i++) begin
            int v = int'(coef_mem[i]);
            if ((is_max && v > bv) || (!is_max && v < bv)) begin
                bv = v;
                bi = i;
            end
        end
        return bi;
    endfunction

    task automatic expect_beat(input int r, input int qb, input int qe,
                               output int eq, output int es, output int ep, output int et);
        int kind = raw_mem[r][DW-1] ? 1 : 0;
        int pmx, pmn, tmx, tmn;
        eq  = ref_raw(qb * 8, r, kind);
        es  = ref_raw(r, qe * 8, kind);
        pmx = ref_coef(0, qb / 4, 1'b1);
        pmn = ref_coef(0, qb / 4, 1'b0);
        ep  = ref_raw(pmx * 32, pmn * 32, 2);
        tmx = ref_coef(qe / 4, NC - 1, 1'b1);
        tmn = ref_coef(qe / 4, NC - 1, 1'b0);
        et  = ref_raw(tmx * 32, tmn * 32, 2);
    endtask

    task automatic pulse_start(input int r, input int qb, input int qe);
        @(negedge clk);
        start     = 1'b1;
        r_idx     = SAMP_AW'(r);
        qrs_begin = L3_AW'(qb);
        qrs_end   = L3_AW'(qe);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (beat_done !== 1'b1 && n < BEAT_LIMIT) begin
            @(negedge clk);
            n++;
        end
        chk("R8 completion pulse seen", int'(beat_done === 1'b1), 1);
    endtask

    initial begin
        int eq, es, ep, et;
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", int'(beat_done), 0);
        chk("R1 q after reset", int'(q_pos), 0);
        chk("R1 t after reset", int'(t_pos), 0);

        // Table of vectors: R2 sign sense, R3 Q, R4 S, R5 P, R6 T.
        for (int k = 0; k < 6; k++) begin
            vec_t v;
            v = VECS[k];
            fill(int'(v.seed));
            raw_mem[v.r][DW-1] = v.neg;
            expect_beat(int'(v.r), int'(v.qb), int'(v.qe), eq, es, ep, et);
            pulse_start(int'(v.r), int'(v.qb), int'(v.qe));
            wait_done();
            chk($sformatf("R3 R2 q vec%0d", k), int'(q_pos), eq);
            chk($sformatf("R4 R2 s vec%0d", k), int'(s_pos), es);
            chk($sformatf("R5 p vec%0d", k), int'(p_pos), ep);
            chk($sformatf("R6 t vec%0d", k), int'(t_pos), et);
            @(negedge clk);
            // R8: one-cycle pulse, outputs held
            chk($sformatf("R8 done low after pulse vec%0d", k), int'(beat_done), 0);
            chk($sformatf("R8 q held vec%0d", k), int'(q_pos), eq);
        end

        // R7: equal values in the Q and S windows keep the first index.
        fill(11);
        for (int i = 320; i <= 400; i++) raw_mem[i] = 12'sd5;
        pulse_start(360, 40, 50);
        wait_done();
        chk("R7 q tie first", int'(q_pos), 320);
        chk("R7 s tie first", int'(s_pos), 360);

        // R10 and R5: most negative sample wins; P window given in reverse order.
        fill(12);
        for (int i = 0; i <= 10; i++) coef_mem[i] = '0;
        coef_mem[5] = 14'sd100;
        coef_mem[2] = -14'sd100;
        for (int i = 64; i <= 160; i++) raw_mem[i] = '0;
        raw_mem[90]  = 12'sd2047;
        raw_mem[120] = -12'sd2048;
        pulse_start(360, 40, 50);
        wait_done();
        chk("R10 R5 p most negative wins", int'(p_pos), 120);

        // R9: a second start during the beat is ignored.
        fill(77);
        raw_mem[500][DW-1] = 1'b1;
        expect_beat(500, 60, 70, eq, es, ep, et);
        pulse_start(500, 60, 70);
        repeat (5) @(negedge clk);
        pulse_start(1000, 120, 130);
        wait_done();
        chk("R9 q from first start", int'(q_pos), eq);
        chk("R9 s from first start", int'(s_pos), es);
        chk("R9 t from first start", int'(t_pos), et);
        repeat (20) @(negedge clk);
        chk("R9 no second completion", int'(beat_done), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule